// File: doc/BRIEF.md
# Cascadable Column Word Loader with Row Frame Store

The block collects one display row of grayscale words. Each word is 10 bits wide. A parallel bus feeds the words into a chain of 48 word-wide stages. A word moves one stage on each rising edge of `clk` at which `shift_en` is high. The last stage drives a cascade bus, so a second identical block can be fed from the first. A word that enters one device leaves it 48 enabled shifts later and enters the next device. Once a row's words are in place, the controller pulls the active-low commit strobe low. The block then copies all 48 words at once into the row of a 16-row frame store selected by a 4-bit address.

The display side reads the frame store one full row at a time. It presents a row address, and one clock later it receives all 48 words of that row side by side. Column 1 is the word that was shifted in first.

The commit logic is a two-state machine. In `CMT_IDLE` the block waits for the strobe. On the first clock edge at which the strobe is sampled low, the row is written and the transition `IDLE_TO_HOLD` is taken. In `CMT_HOLD` no further writes happen while the strobe stays low (`HOLD_STAY`). When the strobe is sampled high, the transition `HOLD_TO_IDLE` re-arms the machine. While the strobe is high in `CMT_IDLE`, the machine stays put (`IDLE_STAY`). Reset always returns the machine to `CMT_IDLE`.

Top module: `colchain_loader`

## Requirements
- R1: On each rising clock edge with `shift_en` high, every chain stage takes the word of the stage before it, and the first stage takes `din`. A word on `din` appears on `dout` after exactly 48 such edges.
- R2: On a rising edge with `shift_en` low, the chain is unchanged. `dout` keeps its value whatever `din` does.
- R3: In a committed row, column slot k (0-based) holds the k-th word of the last 48 shifted. The first of those 48 words goes to `rd_data[9:0]` (column 1), and the last goes to `rd_data[479:470]` (column 48).
- R4: Each low phase of `strobe_n` causes exactly one row write, on the first rising edge at which `strobe_n` is sampled low while the machine is in `CMT_IDLE`. That write stores the chain content from before that edge. Further edges with the strobe still low write nothing.
- R5: The destination row is the value of `wr_row` at the edge of the write. All other rows keep their contents.
- R6: At every rising edge, `rd_data` takes the full 48-word content of row `rd_row`. If that row is written at the same edge, `rd_data` returns the content from before the write.
- R7: A synchronous reset (`rst` high at a rising edge) clears all chain stages to zero, clears `rd_data` to zero, puts the commit machine into `CMT_IDLE`, and performs no row write. Frame store contents are undefined until written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and system clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Qualifies a shift of the word chain |
| din | input | 10 | Incoming grayscale word |
| dout | output | 10 | Last chain stage, cascade output to the next device |
| strobe_n | input | 1 | Active-low commit strobe |
| wr_row | input | 4 | Destination row for a commit |
| rd_row | input | 4 | Row selected for the display-side read |
| rd_data | output | 480 | 48 words of the read row, column 1 in the low bits |

## Verification
The bench builds the block with its default values: 10-bit words, 48 columns and 16 rows. At these sizes, random loads and commits can reach all 16 rows and the full 48-shift cascade delay. They can also reach both column ends of a row, and a read of a row in the same cycle it is being written. The bench keeps a reference model of the chain, the strobe state and the frame store. It compares `dout` and every known row read cycle by cycle, against random enables, data and strobe patterns. Directed cases cover a long strobe low phase while new data streams in, the column order, and the preservation of untouched rows.

// File: rtl/colload_pkg.sv
`timescale 1ns/1ps
package colload_pkg;

    // Commit sequencer states
    typedef enum logic [0:0] {
        CMT_IDLE = 1'b0,   // armed, waiting for the strobe to be sampled low
        CMT_HOLD = 1'b1    // row written, waiting for the strobe to return high
    } commit_state_t;

    localparam int unsigned DEF_WORD_W = 10;
    localparam int unsigned DEF_COLS   = 48;
    localparam int unsigned DEF_ROWS   = 16;

endpackage

// File: rtl/word_shift_chain.sv
`timescale 1ns/1ps
module word_shift_chain #(
    parameter int unsigned WORD_W = 10,
    parameter int unsigned COLS   = 48,
    localparam int unsigned ROW_W = WORD_W * COLS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic [ROW_W-1:0]  col_words
);

    logic [WORD_W-1:0] stage_q [COLS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < COLS; i++) begin
                stage_q[i] <= '0;
            end
        end else if (shift_en) begin
            stage_q[0] <= din;
            for (int i = 1; i < COLS; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[COLS-1];

    // The oldest word (deepest stage) is column 1, in the lowest slot
    for (genvar k = 0; k < COLS; k++) begin : g_col_map
        assign col_words[k*WORD_W +: WORD_W] = stage_q[COLS-1-k];
    end

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(dout)); // R2

    if (COLS >= 2) begin : g_step_chk
        AST_ONE_STAGE_STEP: assert property (@(posedge clk) disable iff (rst)
            shift_en |=> dout == $past(stage_q[COLS-2])); // R1
    end

endmodule

// File: rtl/commit_sequencer.sv
`timescale 1ns/1ps
module commit_sequencer
    import colload_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic wr_en
);

    commit_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CMT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        wr_en   = 1'b0;
        unique case (state_q)
            CMT_IDLE: begin
                if (!strobe_n) begin            // IDLE_TO_HOLD
                    state_d = CMT_HOLD;
                    wr_en   = !rst;
                end
            end
            CMT_HOLD: begin
                if (strobe_n) begin             // HOLD_TO_IDLE
                    state_d = CMT_IDLE;
                end
            end
            default: state_d = CMT_IDLE;
        endcase
    end

    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en); // R4

    AST_HOLD_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> state_q == CMT_HOLD); // R4

    AST_NO_WRITE_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == CMT_HOLD) |-> !wr_en); // R4

    AST_REARM: assert property (@(posedge clk) disable iff (rst)
        (state_q == CMT_HOLD && strobe_n) |=> state_q == CMT_IDLE); // R4

endmodule

// File: rtl/row_frame_store.sv
`timescale 1ns/1ps
module row_frame_store #(
    parameter int unsigned WORD_W = 10,
    parameter int unsigned COLS   = 48,
    parameter int unsigned ROWS   = 16,
    localparam int unsigned ROW_W  = WORD_W * COLS,
    localparam int unsigned ROW_AW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ROW_AW-1:0] wr_row,
    input  logic [ROW_W-1:0]  wr_data,
    input  logic [ROW_AW-1:0] rd_row,
    output logic [ROW_W-1:0]  rd_data
);

    logic [ROW_W-1:0] mem_q [ROWS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_row] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            rd_data <= mem_q[rd_row];
        end
    end

    AST_ROW_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem_q[$past(wr_row)] == $past(wr_data)); // R5

    AST_SAME_ROW_OLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_row == rd_row) |=> rd_data != $past(wr_data)
            || $past(mem_q[rd_row]) == $past(wr_data)); // R6

endmodule

// File: rtl/colchain_loader.sv
`timescale 1ns/1ps
module colchain_loader #(
    parameter int unsigned WORD_W = colload_pkg::DEF_WORD_W,
    parameter int unsigned COLS   = colload_pkg::DEF_COLS,
    parameter int unsigned ROWS   = colload_pkg::DEF_ROWS,
    localparam int unsigned ROW_W  = WORD_W * COLS,
    localparam int unsigned ROW_AW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    input  logic              strobe_n,
    input  logic [ROW_AW-1:0] wr_row,
    input  logic [ROW_AW-1:0] rd_row,
    output logic [ROW_W-1:0]  rd_data
);

    logic [ROW_W-1:0] col_words;
    logic             wr_en;

    word_shift_chain #(
        .WORD_W (WORD_W),
        .COLS   (COLS)
    ) u_chain (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .din       (din),
        .dout      (dout),
        .col_words (col_words)
    );

    commit_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (strobe_n),
        .wr_en    (wr_en)
    );

    row_frame_store #(
        .WORD_W (WORD_W),
        .COLS   (COLS),
        .ROWS   (ROWS)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_data (col_words),
        .rd_row  (rd_row),
        .rd_data (rd_data)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (dout == '0 && rd_data == '0)); // R7

endmodule

// File: tb/colchain_loader_test.sv
`timescale 1ns/1ps
module colchain_loader_test;

    localparam int W    = 10;
    localparam int C    = 48;
    localparam int R    = 16;
    localparam int AW   = 4;
    localparam int RW   = W * C;

    logic          clk = 1'b0;
    logic          rst;
    logic          shift_en;
    logic [W-1:0]  din;
    logic [W-1:0]  dout;
    logic          strobe_n;
    logic [AW-1:0] wr_row;
    logic [AW-1:0] rd_row;
    logic [RW-1:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    colchain_loader uut (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .din      (din),
        .dout     (dout),
        .strobe_n (strobe_n),
        .wr_row   (wr_row),
        .rd_row   (rd_row),
        .rd_data  (rd_data)
    );

    // Reference model
    logic [W-1:0] m_chain [C];
    logic [W-1:0] m_mem   [R][C];
    bit           m_valid [R];
    bit           m_armed;
    logic [W-1:0] m_rd    [C];
    bit           m_rd_known;
    bit           last_en;

    function automatic logic [RW-1:0] pack_rd();
        logic [RW-1:0] v;
        for (int k = 0; k < C; k++) v[k*W +: W] = m_rd[k];
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [RW-1:0] act,
                         input logic [RW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < C; i++) begin
            m_chain[i] = '0;
            m_rd[i]    = '0;
        end
        for (int r = 0; r < R; r++) m_valid[r] = 0;
        m_armed    = 1;
        m_rd_known = 1;
    endtask

    // Apply one cycle of inputs (called near a falling edge), update model, check outputs
    task automatic cyc(input bit en, input logic [W-1:0] d, input bit stb,
                       input logic [AW-1:0] wr, input logic [AW-1:0] rr);
        shift_en = en; din = d; strobe_n = stb; wr_row = wr; rd_row = rr;
        @(posedge clk);
        m_rd_known = m_valid[rr];
        if (m_valid[rr]) for (int k = 0; k < C; k++) m_rd[k] = m_mem[rr][k];
        if (m_armed && !stb) begin
            for (int k = 0; k < C; k++) m_mem[wr][k] = m_chain[C-1-k];
            m_valid[wr] = 1;
        end
        m_armed = stb;
        if (en) begin
            for (int i = C-1; i > 0; i--) m_chain[i] = m_chain[i-1];
            m_chain[0] = d;
        end
        last_en = en;
        @(negedge clk);
        check(dout === m_chain[C-1], last_en ? "R1" : "R2",
              RW'(dout), RW'(m_chain[C-1]));
        if (m_rd_known)
            check(rd_data === pack_rd(), "R6", rd_data, pack_rd());
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; shift_en = 0; din = '0; strobe_n = 1; wr_row = '0; rd_row = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dout === '0 && rd_data === '0, "R7", {dout, rd_data[RW-W-1:0]}, '0);
        rst = 0;

        // Directed: load words 1..48, commit row 3
        for (int i = 0; i < C; i++) cyc(1, W'(i + 1), 1, 4'd0, 4'd0);
        cyc(0, 10'h3FF, 0, 4'd3, 4'd0);
        // hold strobe low while new data streams in: no second write
        for (int i = 0; i < 10; i++) cyc(1, W'(500 + i), 0, 4'd3, 4'd3);
        cyc(0, '0, 1, 4'd3, 4'd3);
        cyc(0, '0, 1, 4'd0, 4'd3);
        check(rd_data[W-1:0] === 10'd1, "R3", RW'(rd_data[W-1:0]), RW'(1));
        check(rd_data[RW-1 -: W] === 10'd48, "R3", RW'(rd_data[RW-1 -: W]), RW'(48));
        check(rd_data[5*W +: W] === 10'd6, "R4", RW'(rd_data[5*W +: W]), RW'(6));

        // Directed: commit row 7 then row 3 again, row 7 must survive
        for (int i = 0; i < C; i++) cyc(1, W'(900 - i), 1, 4'd0, 4'd0);
        cyc(0, '0, 0, 4'd7, 4'd7);   // read row 7 same edge it is written
        cyc(0, '0, 1, 4'd7, 4'd7);
        for (int i = 0; i < 5; i++) cyc(1, W'(i), 1, 4'd0, 4'd0);
        cyc(1, '0, 0, 4'd3, 4'd3);
        cyc(0, '0, 1, 4'd0, 4'd7);
        check(rd_data[W-1:0] === 10'd900, "R5", RW'(rd_data[W-1:0]), RW'(900));

        // Random phase
        for (int n = 0; n < 6000; n++) begin
            cyc(($urandom % 4) != 0, W'($urandom), ($urandom % 8) != 0,
                AW'($urandom), AW'($urandom));
        end

        // Sweep all rows
        for (int r = 0; r < R; r++) cyc(0, W'($urandom), 1, '0, AW'(r));
        cyc(0, '0, 1, '0, '0);
        for (int r = 0; r < R; r++) if (m_valid[r]) n_chk += 0;
        check(n_chk > 12, "R5", RW'(n_chk), RW'(13));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule